// File: doc/BRIEF.md
# Masked Pattern Channel Stimulus Generator

This block produces test traffic for a multi-channel transceiver. It stores six 16-bit patterns, each paired with its own 16-bit enable mask. When running, it plays the patterns in a fixed round-robin order, one per clock. Each pattern leaves the block with its disabled bits forced low. The resulting word is offered at the same time to every channel that is enabled in a 32-bit channel-select mask. At least two channels must be enabled.

The channel word is 32 bits wide and crosses as two 16-bit halves. Both halves carry the same masked pattern. Returned words come back one channel at a time. Each one is compared with the word that was sent a programmable number of cycles earlier. A mismatch counter for each channel records the failures, and any one counter can be read through a selector.

Configuration arrives as 24-bit command words from two sources: a local switch bank and a host port. Commands load patterns, masks, the two halves of the channel mask and the loopback latency, and they start and stop the sequencer.

Top module: `tvg_top`

## Requirements
- R1: After reset, txValid is 0, txChanEn is 0, errFlag is 0, all mismatch counters read 0, every pattern and mask is 0, and the loopback latency is 1.
- R2: A command word holds the opcode in bits 23:20, the slot index in bits 19:16 and the value in bits 15:0. The opcodes are 1 load pattern[index], 2 load mask[index] (index 0..5), 3 load channel mask bits 15:0, 4 load channel mask bits 31:16, 5 set latency to value (1..8), 6 start and 7 stop.
- R3: When both sources present a command in the same cycle, the host command is applied and the switch-bank command is dropped. A switch-bank command on its own is applied.
- R4: While running, txWord equals {p & m, p & m} for the current slot's pattern p and mask m, so a mask bit of 0 drives that bit low.
- R5: A start command with fewer than two channel-mask bits set is rejected: errFlag goes to 1 and the block stays idle. An accepted start clears errFlag.
- R6: In the cycle after an accepted start, slot 0 is emitted. The slots then follow 0,1,2,3,4,5,0,... one per clock until a stop command, and txValid falls in the cycle after the stop.
- R7: While running, txChanEn equals the 32-bit channel mask, which always has at least two bits set. While idle, txChanEn is 0.
- R8: While running, every command other than stop is ignored.
- R9: A returned word on rxChan in cycle c+L is compared with the word sent in cycle c, where L is the latency. Each mismatch on an enabled channel adds one to that channel's counter, read on errCnt by selecting the channel with cntSel. An accepted start clears all counters.
- R10: A returned word on a channel that is not enabled is not counted. A returned word whose comparison slot refers to a cycle that was not sending is also not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swValid | input | 1 | Switch-bank command present |
| swWord | input | 24 | Switch-bank command word |
| hostValid | input | 1 | Host command present |
| hostWord | input | 24 | Host command word |
| txValid | output | 1 | Sequencer is emitting |
| txWord | output | 32 | Channel word (two equal halves) |
| txChanEn | output | 32 | Channels receiving txWord |
| errFlag | output | 1 | Last start rejected |
| rxValid | input | 1 | Returned word present |
| rxChan | input | 5 | Channel of returned word |
| rxWord | input | 32 | Returned word |
| cntSel | input | 5 | Counter to read |
| errCnt | output | 8 | Mismatch count of selected channel |

## Verification
The pattern path is swept over four mask families: all enabled, all masked, a sliding byte and an alternating nibble pattern. Each family runs for more than two full wraps. All-masked output separates a true AND from a pass-through. The shifted masks catch a slot whose mask is paired with the wrong pattern. The loopback is driven from the bench's own record of sent words with a latency of 3, and selected returns are corrupted. This separates counted channels from disabled channels and valid comparisons from early ones. It also shows whether an error is charged to the right channel.

// File: rtl/tvg_pkg.sv
package tvg_pkg;
  localparam int NUM_VEC = 6;
  localparam int VEC_W   = 16;
  localparam int CMD_W   = 24;
  localparam int IDX_W   = 4;
  localparam int OP_W    = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 4'd0,
    OP_VEC   = 4'd1,
    OP_MASK  = 4'd2,
    OP_CHLO  = 4'd3,
    OP_CHHI  = 4'd4,
    OP_LAT   = 4'd5,
    OP_START = 4'd6,
    OP_STOP  = 4'd7
  } opcode_e;

  typedef struct packed {
    logic             ldVec;
    logic             ldMask;
    logic             ldChLo;
    logic             ldChHi;
    logic             ldLat;
    logic             go;
    logic             halt;
    logic [IDX_W-1:0] idx;
    logic [VEC_W-1:0] val;
  } strobe_t;
endpackage

// File: rtl/tvg_ctrl.sv
module tvg_ctrl
  import tvg_pkg::*;
#(
  parameter int MAX_LAT = 8,
  parameter int CNT_CH_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                swValid,
  input  logic [CMD_W-1:0]    swWord,
  input  logic                hostValid,
  input  logic [CMD_W-1:0]    hostWord,
  input  logic [CNT_CH_W-1:0] chanCount,
  output strobe_t             stb,
  output logic                running,
  output logic                errFlag
);
  logic             cmdValid;
  logic [CMD_W-1:0] cmdWord;
  opcode_e          op;
  logic             enough;

  // host source wins over switch bank
  assign cmdValid = hostValid | swValid;
  assign cmdWord  = hostValid ? hostWord : swWord;
  assign op       = opcode_e'(cmdWord[CMD_W-1 -: OP_W]);
  assign enough   = chanCount >= CNT_CH_W'(2);

  always_comb begin
    stb     = '0;
    stb.idx = cmdWord[VEC_W +: IDX_W];
    stb.val = cmdWord[VEC_W-1:0];
    if (cmdValid) begin
      if (running) begin
        stb.halt = (op == OP_STOP);
      end else begin
        case (op)
          OP_VEC:   stb.ldVec  = stb.idx < IDX_W'(NUM_VEC);
          OP_MASK:  stb.ldMask = stb.idx < IDX_W'(NUM_VEC);
          OP_CHLO:  stb.ldChLo = 1'b1;
          OP_CHHI:  stb.ldChHi = 1'b1;
          OP_LAT:   stb.ldLat  = (stb.val != '0) && (stb.val <= VEC_W'(MAX_LAT));
          OP_START: stb.go     = enough;
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (stb.go)        running <= 1'b1;
      else if (stb.halt) running <= 1'b0;
      if (cmdValid && !running && op == OP_START) errFlag <= !enough;
    end
  end
endmodule

// File: rtl/tvg_datapath.sv
module tvg_datapath
  import tvg_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int MAX_LAT = 8,
  parameter int CNT_W   = 8,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int CNT_CH_W = $clog2(NUM_CH + 1),
  localparam int LAT_W    = $clog2(MAX_LAT + 1),
  localparam int HALF     = NUM_CH / 2,
  localparam int WORD_W   = 2 * VEC_W,
  localparam int SEQ_W    = $clog2(NUM_VEC)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic                running,
  input  logic                rxValid,
  input  logic [CH_W-1:0]     rxChan,
  input  logic [WORD_W-1:0]   rxWord,
  input  logic [CH_W-1:0]     cntSel,
  output logic                txValid,
  output logic [WORD_W-1:0]   txWord,
  output logic [NUM_CH-1:0]   txChanEn,
  output logic [CNT_CH_W-1:0] chanCount,
  output logic [CNT_W-1:0]    errCnt,
  output logic [SEQ_W-1:0]    seqIdx,
  output logic [NUM_CH-1:0]   chanMask
);
  logic [VEC_W-1:0]  vecQ  [NUM_VEC];
  logic [VEC_W-1:0]  maskQ [NUM_VEC];
  logic [LAT_W-1:0]  latQ;
  logic [VEC_W-1:0]  masked;
  logic [WORD_W-1:0] expWord [MAX_LAT];
  logic [MAX_LAT-1:0] expVld;
  logic [CNT_W-1:0]  cntQ [NUM_CH];
  logic [LAT_W-1:0]  tap;
  logic              miss;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        vecQ[i]  <= '0;
        maskQ[i] <= '0;
      end
      chanMask <= '0;
      latQ     <= LAT_W'(1);
    end else begin
      if (stb.ldVec)  vecQ[stb.idx[SEQ_W-1:0]]  <= stb.val;
      if (stb.ldMask) maskQ[stb.idx[SEQ_W-1:0]] <= stb.val;
      if (stb.ldChLo) chanMask[HALF-1:0]       <= stb.val[HALF-1:0];
      if (stb.ldChHi) chanMask[NUM_CH-1:HALF]  <= stb.val[HALF-1:0];
      if (stb.ldLat)  latQ <= stb.val[LAT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.go) seqIdx <= '0;
    else if (running)    seqIdx <= (seqIdx == SEQ_W'(NUM_VEC-1)) ? '0 : seqIdx + 1'b1;
  end

  assign masked    = vecQ[seqIdx] & maskQ[seqIdx];
  assign txValid   = running;
  assign txWord    = {masked, masked};
  assign txChanEn  = running ? chanMask : '0;
  assign chanCount = CNT_CH_W'($countones(chanMask));

  // expected-word delay line
  always_ff @(posedge clk) begin
    if (!rstN || stb.go) begin
      expVld <= '0;
    end else begin
      expVld <= {expVld[MAX_LAT-2:0], running};
    end
    expWord[0] <= txWord;
    for (int i = 1; i < MAX_LAT; i++) expWord[i] <= expWord[i-1];
  end

  assign tap  = latQ - 1'b1;
  assign miss = rxValid && chanMask[rxChan] && expVld[tap] && (rxWord != expWord[tap]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN || stb.go) cntQ[c] <= '0;
      else if (miss && rxChan == CH_W'(c) && cntQ[c] != '1) cntQ[c] <= cntQ[c] + 1'b1;
    end
  end

  assign errCnt = cntQ[cntSel];
endmodule

// File: rtl/tvg_top.sv
module tvg_top
  import tvg_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int MAX_LAT = 8,
  parameter int CNT_W   = 8,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int CNT_CH_W = $clog2(NUM_CH + 1),
  localparam int WORD_W   = 2 * VEC_W,
  localparam int SEQ_W    = $clog2(NUM_VEC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swValid,
  input  logic [CMD_W-1:0]  swWord,
  input  logic              hostValid,
  input  logic [CMD_W-1:0]  hostWord,
  output logic              txValid,
  output logic [WORD_W-1:0] txWord,
  output logic [NUM_CH-1:0] txChanEn,
  output logic              errFlag,
  input  logic              rxValid,
  input  logic [CH_W-1:0]   rxChan,
  input  logic [WORD_W-1:0] rxWord,
  input  logic [CH_W-1:0]   cntSel,
  output logic [CNT_W-1:0]  errCnt
);
  strobe_t             stb;
  logic                running;
  logic [CNT_CH_W-1:0] chanCount;
  logic [SEQ_W-1:0]    seqIdx;
  logic [NUM_CH-1:0]   chanMask;

  tvg_ctrl #(.MAX_LAT(MAX_LAT), .CNT_CH_W(CNT_CH_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .swValid(swValid), .swWord(swWord),
    .hostValid(hostValid), .hostWord(hostWord),
    .chanCount(chanCount), .stb(stb),
    .running(running), .errFlag(errFlag)
  );

  tvg_datapath #(.NUM_CH(NUM_CH), .MAX_LAT(MAX_LAT), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .running(running),
    .rxValid(rxValid), .rxChan(rxChan), .rxWord(rxWord), .cntSel(cntSel),
    .txValid(txValid), .txWord(txWord), .txChanEn(txChanEn),
    .chanCount(chanCount), .errCnt(errCnt), .seqIdx(seqIdx), .chanMask(chanMask)
  );
endmodule

// File: rtl/tvg_chk.sv
module tvg_chk #(
  parameter int NUM_CH = 32,
  parameter int SEQ_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              txValid,
  input logic [NUM_CH-1:0] txChanEn,
  input logic              errFlag,
  input logic [SEQ_W-1:0]  seqIdx
);
  // R7
  chan_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $countones(txChanEn) >= 2);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txValid |-> txChanEn == '0);
  // R6
  seq_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txValid) |-> seqIdx == '0);
  // R6
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && $past(txValid)) |->
      seqIdx == (($past(seqIdx) == SEQ_W'(5)) ? '0 : $past(seqIdx) + 1'b1));
  // R5
  err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> !txValid);
  // R8
  frozen_chan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && $past(txValid)) |-> $stable(txChanEn));
endmodule

bind tvg_top tvg_chk #(.NUM_CH(NUM_CH), .SEQ_W(SEQ_W)) chk_i (
  .clk(clk), .rstN(rstN), .txValid(txValid), .txChanEn(txChanEn),
  .errFlag(errFlag), .seqIdx(seqIdx)
);

// File: tb/tvg_top_tb_top.sv
module tvg_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swValid = 1'b0, hostValid = 1'b0, rxValid = 1'b0;
  logic [23:0] swWord = '0, hostWord = '0;
  logic [4:0]  rxChan = '0, cntSel = '0;
  logic [31:0] rxWord = '0;
  logic        txValid, errFlag;
  logic [31:0] txWord, txChanEn;
  logic [7:0]  errCnt;
  int nTests = 0, nFail = 0;
  logic [15:0] vecM [6];
  logic [15:0] mskM [6];
  logic [31:0] hist [32];

  always #5 clk = ~clk;

  tvg_top dut_i (
    .clk(clk), .rstN(rstN), .swValid(swValid), .swWord(swWord),
    .hostValid(hostValid), .hostWord(hostWord), .txValid(txValid),
    .txWord(txWord), .txChanEn(txChanEn), .errFlag(errFlag),
    .rxValid(rxValid), .rxChan(rxChan), .rxWord(rxWord),
    .cntSel(cntSel), .errCnt(errCnt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host(input logic [3:0] op, input logic [3:0] idx, input logic [15:0] val);
    @(negedge clk);
    hostValid = 1'b1; hostWord = {op, idx, val};
    @(negedge clk);
    hostValid = 1'b0;
  endtask

  function automatic logic [15:0] famMask(input int f, input int i);
    case (f)
      0: return 16'hFFFF;
      1: return 16'h0000;
      2: return 16'h00FF << i;
      default: return (i % 2 == 0) ? 16'hF0F0 : 16'h0F0F;
    endcase
  endfunction

  // after start task returns, the current negedge shows slot 0
  task automatic runSweep(input string req, input int cycles);
    for (int k = 0; k < cycles; k++) begin
      check(req, txWord, {vecM[k%6] & mskM[k%6], vecM[k%6] & mskM[k%6]});
      check("R7", txChanEn, 32'h0010_0020);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", {31'd0, txValid}, 32'd0);
    check("R1", txChanEn, 32'd0);
    check("R1", {31'd0, errFlag}, 32'd0);
    cntSel = 5'd5; #1 check("R1", {24'd0, errCnt}, 32'd0);

    // R5 start with one channel rejected
    host(4'd3, 4'd0, 16'h0020);
    host(4'd6, 4'd0, 16'h0);
    check("R5", {31'd0, errFlag}, 32'd1);
    check("R5", {31'd0, txValid}, 32'd0);

    for (int i = 0; i < 6; i++) begin
      vecM[i] = 16'hA5C3 ^ (16'h1111 * 16'(i + 1));
      host(4'd1, 4'(i), vecM[i]);
    end
    host(4'd4, 4'd0, 16'h0010); // R2 upper half: channel 20

    // R4 R6 sweep of mask families
    for (int f = 0; f < 4; f++) begin
      for (int i = 0; i < 6; i++) begin
        mskM[i] = famMask(f, i);
        host(4'd2, 4'(i), mskM[i]);
      end
      host(4'd6, 4'd0, 16'h0);
      check("R5", {31'd0, errFlag}, 32'd0);
      check("R6", {31'd0, txValid}, 32'd1);
      runSweep(f == 1 ? "R4" : "R6", 14);
      host(4'd7, 4'd0, 16'h0);
      check("R6", {31'd0, txValid}, 32'd0);
      check("R7", txChanEn, 32'd0);
    end

    // R8 writes while running ignored
    for (int i = 0; i < 6; i++) begin mskM[i] = 16'hFFFF; host(4'd2, 4'(i), 16'hFFFF); end
    host(4'd6, 4'd0, 16'h0);
    @(negedge clk); hostValid = 1'b1; hostWord = {4'd1, 4'd0, 16'hDEAD};
    @(negedge clk); hostWord = {4'd3, 4'd0, 16'h0000};
    @(negedge clk); hostValid = 1'b0;
    check("R8", txChanEn, 32'h0010_0020);
    host(4'd7, 4'd0, 16'h0);
    host(4'd6, 4'd0, 16'h0);
    check("R8", txWord, {vecM[0], vecM[0]});
    check("R8", txChanEn, 32'h0010_0020);
    host(4'd7, 4'd0, 16'h0);

    // R3 host wins; switch alone applies
    @(negedge clk);
    swValid = 1'b1; swWord = {4'd1, 4'd1, 16'h1111};
    hostValid = 1'b1; hostWord = {4'd1, 4'd1, 16'h2222};
    @(negedge clk);
    hostValid = 1'b0; swWord = {4'd1, 4'd2, 16'h3333};
    @(negedge clk);
    swValid = 1'b0;
    vecM[1] = 16'h2222; vecM[2] = 16'h3333;
    host(4'd6, 4'd0, 16'h0);
    @(negedge clk);
    check("R3", txWord, 32'h2222_2222);
    @(negedge clk);
    check("R3", txWord, 32'h3333_3333);
    host(4'd7, 4'd0, 16'h0);

    // R9 R10 loopback with latency 3
    host(4'd5, 4'd0, 16'd3);
    host(4'd6, 4'd0, 16'h0);
    for (int k = 0; k < 20; k++) begin
      hist[k] = txWord;
      rxValid = 1'b0;
      if (k == 1) begin
        rxValid = 1'b1; rxChan = 5'd5; rxWord = 32'hFFFF_0000; // R10 nothing sent yet
      end else if (k >= 3) begin
        rxValid = 1'b1;
        rxChan = (k % 2 == 0) ? 5'd5 : 5'd20;
        rxWord = hist[k-3] ^ ((k % 4 == 0) ? 32'h1 : 32'h0);
        if (k == 7) begin rxChan = 5'd9; rxWord = ~hist[4]; end // R10 disabled channel
      end
      @(negedge clk);
    end
    rxValid = 1'b0;
    host(4'd7, 4'd0, 16'h0);
    cntSel = 5'd5;  #1 check("R9", {24'd0, errCnt}, 32'd4);
    cntSel = 5'd20; #1 check("R9", {24'd0, errCnt}, 32'd0);
    cntSel = 5'd9;  #1 check("R10", {24'd0, errCnt}, 32'd0);
    host(4'd6, 4'd0, 16'h0);
    cntSel = 5'd5;  #1 check("R9", {24'd0, errCnt}, 32'd0);
    host(4'd7, 4'd0, 16'h0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule